// File: doc/BRIEF.md
# SD Command Launch Sequencer

This block sits between a host register file and a card-side command engine of an SD/MMC host. Software first writes a 32-bit argument and then a 32-bit command word. When the word has its start flag set, the sequencer decodes the option flags and the command index. It presents them, together with the argument, as one held request toward the engine. It then waits for the engine to report completion, captures the response words and raises single-cycle interrupt pulses.

The start flag reads back as busy until the engine takes the command. Software polls it with a timeout of its own. A command that expects a response but hears nothing within a programmable number of card clock ticks is closed with a timeout pulse, followed by the usual done pulse. A second kind of launch, marked by the clock-update flag, never reaches the engine. It waits a fixed number of system clocks and then copies the pending clock settings into the active set, without raising a done interrupt.

Top module: `sdcmd_issuer`

## Requirements
- R1: After reset, start_busy, eng_req, irq_done, irq_err, irq_tmo, resp_out and clk_active are all zero.
- R2: A cmd_wr in the idle state whose word has bit 31 set and bit 21 clear raises eng_req in the next cycle. In that cycle eng_index equals word bits 5:0, eng_arg equals the last argument written, and start_busy reads 1 from the cycle after the write until acceptance.
- R3: On the clock edge where eng_req and eng_ack are both high, the command is taken: eng_req and start_busy both read 0 from the next cycle.
- R4: eng_opts[k] equals command word bit 6+k for k = 0..9. Those bits mean: 6 response expected, 7 long response, 8 response CRC check, 9 data phase, 10 write direction, 11 stream mode, 12 automatic stop, 13 wait for previous data, 14 stop/abort, 15 send init sequence. eng_opts, eng_index and eng_arg stay stable while eng_req waits for eng_ack.
- R5: An eng_done pulse after acceptance gives a one-cycle irq_done in the next cycle. irq_err in that same cycle equals the eng_err that came with eng_done.
- R6: For a command with bits 6 and 7 set, eng_done loads resp_out word k (bits 32k+31:32k) from eng_resp word k for k = 0..3, so the most significant word lands in word 3.
- R7: For bit 6 set and bit 7 clear, only resp_out word 0 is loaded from eng_resp[31:0] and words 1..3 keep their values. For bit 6 clear, resp_out is not changed.
- R8: For a command with bit 6 set and no eng_done, the L-th card_tick after acceptance (L = tmo_limit, with 0 treated as 1) gives a one-cycle irq_tmo in the next cycle and a one-cycle irq_done in the cycle after that.
- R9: A command with bit 6 clear never times out; it waits for eng_done whatever the number of card ticks.
- R10: A launch with bits 31 and 21 set never raises eng_req or irq_done. start_busy reads 1 for exactly UPD_CYCLES cycles after the write, and when it falls clk_active equals clk_pending.
- R11: cmd_wr and arg_wr are ignored while a command is in flight (not idle): the held request does not change and no new command starts afterwards.
- R12: A cmd_wr whose word has bit 31 clear starts nothing. eng_done or eng_err arriving while idle raises no interrupt and leaves resp_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word |
| arg_wr | input | 1 | Argument write strobe |
| arg_wdata | input | 32 | Argument value |
| start_busy | output | 1 | Start flag read-back |
| clk_pending | input | CLK_W | Clock settings staged by software |
| clk_active | output | CLK_W | Clock settings in force |
| tmo_limit | input | TMO_W | Response timeout in card ticks |
| card_tick | input | 1 | One pulse per card clock |
| eng_req | output | 1 | Command request to the engine |
| eng_ack | input | 1 | Engine takes the request |
| eng_index | output | 6 | Command index |
| eng_arg | output | 32 | Command argument |
| eng_opts | output | 10 | Decoded option flags |
| eng_done | input | 1 | Engine finished the command |
| eng_err | input | 1 | Engine reports an error with done |
| eng_resp | input | 128 | Response bits from the engine |
| resp_out | output | 128 | Captured response words |
| irq_done | output | 1 | Command-done pulse |
| irq_err | output | 1 | Command-error pulse |
| irq_tmo | output | 1 | Response-timeout pulse |

## Verification
The bench builds the block with an 8-bit timeout width and UPD_CYCLES of 3. This keeps both timeout expiry and the end of a clock-update launch within a few cycles, so their exact edges can be checked one cycle at a time. Limits of 0 and 3 cover the lowest count and an ordinary count. With card_tick held high, each cycle after acceptance counts one tick, so the cycle of expiry follows directly from the limit.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  localparam int START_POS   = 31;
  localparam int CLKONLY_POS = 21;
  localparam int IDX_W       = 6;
  localparam int OPT_LO      = 6;
  localparam int OPT_W       = 10;

  // Field order follows the command word bits 15 down to 6.
  typedef struct packed {
    logic init_seq;
    logic stop_abort;
    logic wait_prev;
    logic auto_stop;
    logic stream;
    logic write_dir;
    logic has_data;
    logic crc_chk;
    logic long_resp;
    logic resp_exp;
  } cmd_opts_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_FIN,
    ST_CLK
  } seq_state_t;

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic [31:0]      word,
  output logic             launch,
  output logic             clk_only,
  output logic [IDX_W-1:0] idx,
  output cmd_opts_t        opts
);

  logic unused_bits;

  always_comb begin
    launch   = word[START_POS];
    clk_only = word[CLKONLY_POS];
    idx      = word[IDX_W-1:0];
    opts     = cmd_opts_t'(word[OPT_LO+OPT_W-1:OPT_LO]);
  end

  assign unused_bits = ^{word[30:22], word[20:16]};

endmodule

// File: rtl/sdcmd_timer.sv
module sdcmd_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);

  logic [TMO_W-1:0] cnt;
  logic [TMO_W-1:0] lim_eff;
  logic [TMO_W:0]   nxt;

  always_comb begin
    lim_eff = (limit == '0) ? TMO_W'(1) : limit;
    nxt     = {1'b0, cnt} + (TMO_W+1)'(1);
    expire  = run && tick && (nxt >= {1'b0, lim_eff});
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick && !expire) begin
      cnt <= cnt + TMO_W'(1);
    end
  end

  // R8: once the window expires the sequencer leaves the waiting state
  p_expire_stops_r8: assert property (@(posedge clk) disable iff (rst)
    expire |=> !run);

endmodule

// File: rtl/sdcmd_resp.sv
module sdcmd_resp #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cap,
  input  logic                    long_sel,
  input  logic [WORDS*WORD_W-1:0] din,
  output logic [WORDS*WORD_W-1:0] dout
);

  genvar k;
  generate
    for (k = 0; k < WORDS; k++) begin : g_word
      logic load;
      if (k == 0) begin : g_low
        assign load = cap;
      end else begin : g_high
        assign load = cap && long_sel;
      end
      always_ff @(posedge clk) begin
        if (rst) begin
          dout[k*WORD_W +: WORD_W] <= '0;
        end else if (load) begin
          dout[k*WORD_W +: WORD_W] <= din[k*WORD_W +: WORD_W];
        end
      end
    end
  endgenerate

  // R7: a short capture leaves the upper words alone
  p_short_keeps_upper_r7: assert property (@(posedge clk) disable iff (rst)
    (cap && !long_sel) |=> $stable(dout[WORDS*WORD_W-1:WORD_W]));

endmodule

// File: rtl/sdcmd_issuer.sv
module sdcmd_issuer
  import sdcmd_pkg::*;
#(
  parameter int TMO_W      = 16,
  parameter int CLK_W      = 16,
  parameter int UPD_CYCLES = 4,
  parameter int WORD_W     = 32,
  parameter int RESP_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cmd_wr,
  input  logic [31:0]                  cmd_wdata,
  input  logic                         arg_wr,
  input  logic [31:0]                  arg_wdata,
  output logic                         start_busy,
  input  logic [CLK_W-1:0]             clk_pending,
  output logic [CLK_W-1:0]             clk_active,
  input  logic [TMO_W-1:0]             tmo_limit,
  input  logic                         card_tick,
  output logic                         eng_req,
  input  logic                         eng_ack,
  output logic [5:0]                   eng_index,
  output logic [31:0]                  eng_arg,
  output logic [9:0]                   eng_opts,
  input  logic                         eng_done,
  input  logic                         eng_err,
  input  logic [RESP_WORDS*WORD_W-1:0] eng_resp,
  output logic [RESP_WORDS*WORD_W-1:0] resp_out,
  output logic                         irq_done,
  output logic                         irq_err,
  output logic                         irq_tmo
);

  localparam int UPD_W = $clog2(UPD_CYCLES + 1);

  seq_state_t       st;
  logic [31:0]      arg_q;
  cmd_opts_t        opts_q;
  logic [UPD_W-1:0] upd_cnt;

  logic             dec_launch;
  logic             dec_clk_only;
  logic [IDX_W-1:0] dec_idx;
  cmd_opts_t        dec_opts;
  logic             tmo_run;
  logic             tmo_hit;
  logic             resp_cap;

  sdcmd_decode u_dec (
    .word     (cmd_wdata),
    .launch   (dec_launch),
    .clk_only (dec_clk_only),
    .idx      (dec_idx),
    .opts     (dec_opts)
  );

  assign tmo_run  = (st == ST_WAIT) && opts_q.resp_exp;
  assign resp_cap = (st == ST_WAIT) && eng_done && opts_q.resp_exp;

  sdcmd_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .run    (tmo_run),
    .tick   (card_tick),
    .limit  (tmo_limit),
    .expire (tmo_hit)
  );

  sdcmd_resp #(.WORD_W(WORD_W), .WORDS(RESP_WORDS)) u_resp (
    .clk      (clk),
    .rst      (rst),
    .cap      (resp_cap),
    .long_sel (opts_q.long_resp),
    .din      (eng_resp),
    .dout     (resp_out)
  );

  assign eng_opts = opts_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      arg_q      <= '0;
      opts_q     <= '0;
      upd_cnt    <= '0;
      start_busy <= 1'b0;
      eng_req    <= 1'b0;
      eng_index  <= '0;
      eng_arg    <= '0;
      clk_active <= '0;
      irq_done   <= 1'b0;
      irq_err    <= 1'b0;
      irq_tmo    <= 1'b0;
    end else begin
      irq_done <= 1'b0;
      irq_err  <= 1'b0;
      irq_tmo  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (arg_wr) begin
            arg_q <= arg_wdata;
          end
          if (cmd_wr && dec_launch) begin
            start_busy <= 1'b1;
            if (dec_clk_only) begin
              st      <= ST_CLK;
              upd_cnt <= '0;
            end else begin
              st        <= ST_REQ;
              eng_req   <= 1'b1;
              eng_index <= dec_idx;
              eng_arg   <= arg_wr ? arg_wdata : arg_q;
              opts_q    <= dec_opts;
            end
          end
        end
        ST_REQ: begin
          if (eng_ack) begin
            eng_req    <= 1'b0;
            start_busy <= 1'b0;
            st         <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (eng_done) begin
            irq_done <= 1'b1;
            irq_err  <= eng_err;
            st       <= ST_IDLE;
          end else if (tmo_hit) begin
            irq_tmo <= 1'b1;
            st      <= ST_FIN;
          end
        end
        ST_FIN: begin
          irq_done <= 1'b1;
          st       <= ST_IDLE;
        end
        ST_CLK: begin
          if (upd_cnt == UPD_W'(UPD_CYCLES - 1)) begin
            clk_active <= clk_pending;
            start_busy <= 1'b0;
            st         <= ST_IDLE;
          end else begin
            upd_cnt <= upd_cnt + UPD_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2: a request is only ever shown while the start flag reads set
  p_req_needs_busy_r2: assert property (@(posedge clk) disable iff (rst)
    eng_req |-> start_busy);

  // R3: acceptance clears the start flag and the request
  p_accept_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (eng_req && eng_ack) |=> (!start_busy && !eng_req));

  // R4: the request fields hold until the engine takes them
  p_hold_fields_r4: assert property (@(posedge clk) disable iff (rst)
    (eng_req && !eng_ack) |=> (eng_req && $stable(eng_index) &&
                               $stable(eng_arg) && $stable(eng_opts)));

  // R5: done is a single-cycle pulse
  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    irq_done |=> !irq_done);

  // R8: a timeout is followed by done in the next cycle
  p_tmo_then_done_r8: assert property (@(posedge clk) disable iff (rst)
    irq_tmo |=> irq_done);

  // R10: a clock-update launch stays off the engine and the done line
  p_clk_only_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CLK) |-> (!eng_req && !irq_done));

endmodule

// File: tb/sim_sdcmd_issuer.sv
module sim_sdcmd_issuer;

  localparam int TMO_W = 8;
  localparam int CLK_W = 16;
  localparam int UPD   = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_wr = 1'b0;
  logic [31:0]  cmd_wdata = '0;
  logic         arg_wr = 1'b0;
  logic [31:0]  arg_wdata = '0;
  logic         start_busy;
  logic [CLK_W-1:0] clk_pending = '0;
  logic [CLK_W-1:0] clk_active;
  logic [TMO_W-1:0] tmo_limit = 8'd255;
  logic         card_tick = 1'b1;
  logic         eng_req;
  logic         eng_ack = 1'b0;
  logic [5:0]   eng_index;
  logic [31:0]  eng_arg;
  logic [9:0]   eng_opts;
  logic         eng_done = 1'b0;
  logic         eng_err = 1'b0;
  logic [127:0] eng_resp = '0;
  logic [127:0] resp_out;
  logic         irq_done;
  logic         irq_err;
  logic         irq_tmo;

  int total = 0;
  int bad = 0;
  bit ended = 1'b0;
  logic [127:0] model = '0;

  always #5 clk = ~clk;

  sdcmd_issuer #(.TMO_W(TMO_W), .CLK_W(CLK_W), .UPD_CYCLES(UPD)) u0 (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .arg_wr(arg_wr), .arg_wdata(arg_wdata), .start_busy(start_busy),
    .clk_pending(clk_pending), .clk_active(clk_active),
    .tmo_limit(tmo_limit), .card_tick(card_tick), .eng_req(eng_req),
    .eng_ack(eng_ack), .eng_index(eng_index), .eng_arg(eng_arg),
    .eng_opts(eng_opts), .eng_done(eng_done), .eng_err(eng_err),
    .eng_resp(eng_resp), .resp_out(resp_out), .irq_done(irq_done),
    .irq_err(irq_err), .irq_tmo(irq_tmo)
  );

  function automatic logic [9:0] want_opts(input logic [31:0] w);
    return w[15:6];
  endfunction

  function automatic logic [127:0] next_model(input logic [127:0] m,
                                              input logic [31:0] w,
                                              input logic [127:0] r);
    logic [127:0] n = m;
    if (w[6]) begin
      if (w[7]) n = r;
      else n[31:0] = r[31:0];
    end
    return n;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick1();
    @(posedge clk); #1;
  endtask

  // Launch and accept a command; leaves the block waiting for done.
  task automatic launch(input logic [31:0] w, input logic [31:0] a,
                        input int ack_wait);
    arg_wr = 1'b1; arg_wdata = a;
    tick1();
    arg_wr = 1'b0; cmd_wr = 1'b1; cmd_wdata = w;
    tick1();
    cmd_wr = 1'b0;
    chk(eng_req === 1'b1, "R2 req raised", 128'(eng_req), 128'(1));
    chk(start_busy === 1'b1, "R2 busy set", 128'(start_busy), 128'(1));
    chk(eng_index === w[5:0], "R2 index", 128'(eng_index), 128'(w[5:0]));
    chk(eng_arg === a, "R2 arg", 128'(eng_arg), 128'(a));
    chk(eng_opts === want_opts(w), "R4 opts", 128'(eng_opts), 128'(want_opts(w)));
    for (int i = 0; i < ack_wait; i++) begin
      tick1();
      chk(eng_req === 1'b1 && eng_opts === want_opts(w) && eng_arg === a,
          "R4 hold", 128'(eng_opts), 128'(want_opts(w)));
    end
    eng_ack = 1'b1;
    tick1();
    eng_ack = 1'b0;
    chk(start_busy === 1'b0 && eng_req === 1'b0, "R3 start cleared",
        128'({start_busy, eng_req}), 128'(0));
  endtask

  task automatic finish_cmd(input logic [31:0] w, input logic [127:0] r,
                            input bit err);
    eng_done = 1'b1; eng_err = err; eng_resp = r;
    tick1();
    eng_done = 1'b0; eng_err = 1'b0;
    model = next_model(model, w, r);
    chk(irq_done === 1'b1, "R5 done pulse", 128'(irq_done), 128'(1));
    chk(irq_err === err, "R5 err flag", 128'(irq_err), 128'(err));
    chk(resp_out === model, w[7] ? "R6 long resp" : "R7 short/no resp",
        resp_out, model);
    tick1();
    chk(irq_done === 1'b0, "R5 done single", 128'(irq_done), 128'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [127:0] r;
    void'($urandom(32'h5eed_0001));
    repeat (3) tick1();
    rst = 1'b0;
    tick1();
    // R1 reset state
    chk({start_busy, eng_req, irq_done, irq_err, irq_tmo} === 5'b0,
        "R1 reset flags", 128'({start_busy, eng_req, irq_done}), 128'(0));
    chk(resp_out === '0 && clk_active === '0, "R1 reset regs", resp_out, 128'(0));

    // Directed: short, long, no-response, data write commands
    w = 32'h8000_0151; r = 128'h4444_4444_3333_3333_2222_2222_1111_1111;
    launch(w, 32'hdead_beef, 0); finish_cmd(w, r, 1'b0);
    w = 32'h8000_01C2; r = 128'hAAAA_0003_BBBB_0002_CCCC_0001_DDDD_0000;
    launch(w, 32'h1234_5678, 2); finish_cmd(w, r, 1'b0);
    w = 32'h8000_8000; r = 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF;
    launch(w, 32'h0, 1); finish_cmd(w, r, 1'b0);          // R7 no response
    w = 32'h8000_3758; r = 128'h5;
    launch(w, 32'h0000_0200, 0); finish_cmd(w, r, 1'b1);

    // R9: no-response command ignores card ticks
    tmo_limit = 8'd2;
    w = 32'h8000_0000;
    launch(w, 32'h1, 0);
    for (int i = 0; i < 6; i++) begin
      tick1();
      chk(irq_tmo === 1'b0 && irq_done === 1'b0, "R9 no timeout",
          128'({irq_tmo, irq_done}), 128'(0));
    end
    finish_cmd(w, 128'h9, 1'b0);

    // R8: timeout with limit 3
    tmo_limit = 8'd3;
    w = 32'h8000_0148;
    launch(w, 32'h2, 0);
    tick1(); tick1();
    chk(irq_tmo === 1'b0, "R8 not yet", 128'(irq_tmo), 128'(0));
    tick1();
    chk(irq_tmo === 1'b1 && irq_done === 1'b0, "R8 tmo pulse",
        128'({irq_tmo, irq_done}), 128'(2));
    tick1();
    chk(irq_done === 1'b1 && irq_tmo === 1'b0, "R8 done after tmo",
        128'({irq_tmo, irq_done}), 128'(1));
    // R12: late done while idle is ignored
    tick1();
    eng_done = 1'b1; eng_err = 1'b1; eng_resp = ~model;
    tick1();
    eng_done = 1'b0; eng_err = 1'b0;
    chk(irq_done === 1'b0 && irq_err === 1'b0 && resp_out === model,
        "R12 idle done ignored", resp_out, model);

    // R8: limit 0 acts as 1
    tmo_limit = 8'd0;
    launch(w, 32'h3, 0);
    tick1();
    chk(irq_tmo === 1'b1, "R8 limit zero", 128'(irq_tmo), 128'(1));
    tick1();
    tmo_limit = 8'd255;

    // R12: write without start bit does nothing
    cmd_wr = 1'b1; cmd_wdata = 32'h0000_0151;
    tick1();
    cmd_wr = 1'b0;
    chk(eng_req === 1'b0 && start_busy === 1'b0, "R12 no start",
        128'({eng_req, start_busy}), 128'(0));

    // R11: writes while busy are ignored
    w = 32'h8000_0145;
    arg_wr = 1'b1; arg_wdata = 32'hCAFE_0001;
    tick1();
    arg_wr = 1'b0; cmd_wr = 1'b1; cmd_wdata = w;
    tick1();
    cmd_wr = 1'b1; cmd_wdata = 32'h8000_003F; arg_wr = 1'b1; arg_wdata = 32'h0;
    tick1();
    cmd_wr = 1'b0; arg_wr = 1'b0;
    chk(eng_index === 6'h05 && eng_arg === 32'hCAFE_0001, "R11 req untouched",
        128'(eng_index), 128'(5));
    eng_ack = 1'b1;
    tick1();
    eng_ack = 1'b0;
    cmd_wr = 1'b1; cmd_wdata = 32'h8000_002A;
    tick1();
    cmd_wr = 1'b0;
    finish_cmd(w, 128'h77, 1'b0);
    chk(eng_req === 1'b0 && start_busy === 1'b0, "R11 no later launch",
        128'({eng_req, start_busy}), 128'(0));

    // R10: clock-update-only launch
    clk_pending = 16'hA5C3;
    cmd_wr = 1'b1; cmd_wdata = 32'h8020_0151;
    tick1();
    cmd_wr = 1'b0;
    chk(start_busy === 1'b1, "R10 busy", 128'(start_busy), 128'(1));
    for (int i = 0; i < UPD - 1; i++) begin
      tick1();
      chk(start_busy === 1'b1 && eng_req === 1'b0 && irq_done === 1'b0,
          "R10 in progress", 128'({start_busy, eng_req, irq_done}), 128'(4));
    end
    tick1();
    chk(start_busy === 1'b0 && clk_active === 16'hA5C3, "R10 loaded",
        128'(clk_active), 128'(16'hA5C3));
    tick1();
    chk(irq_done === 1'b0 && eng_req === 1'b0, "R10 no done",
        128'({irq_done, eng_req}), 128'(0));

    // Random commands
    for (int n = 0; n < 40; n++) begin
      w = $urandom;
      w[31] = 1'b1; w[21] = 1'b0;
      r = {$urandom, $urandom, $urandom, $urandom};
      launch(w, $urandom, int'($urandom % 4));
      finish_cmd(w, r, 1'($urandom));
    end

    ended = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule